// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block takes a single-cycle write request (an address and a data word) from a synchronous requester. It plays that request out as a write-enable-controlled write on an asynchronous static RAM bus. It drives the RAM address, the active-low chip enable and write enable, the write data with its tri-state output enable, and an active-low store-control line. The store-control line is kept inactive (high) throughout.

Every phase length is a whole number of clock cycles. The lengths are derived at elaboration time from the clock period and a speed-grade parameter, which selects either the 35 ns or the 45 ns timing set. A write passes through three phases:

1. Setup: chip enable is low and write enable is high.
2. Pulse: write enable is low and data is driven.
3. Recover: write enable is high and the address is still held.

After recover the block returns to idle and pulses `done_o` for one cycle. While a write is in progress, `busy_o` is high, `req_ready_o` is low and new requests are dropped.

Top module: `sram_wr_seq`

Cycle counts, with t the clock period in ns and c(x) = max(1, ceil(x/t)):
- PULSE = max(c(write pulse), c(data setup)).
- SETUP = max(1, max(c(addr-to-end), c(CE-to-end)) − PULSE).
- RECOVER = max(1, c(write cycle) − SETUP − PULSE).
- TOTAL = SETUP + PULSE + RECOVER.

The timing values are:
- Fast grade (35): cycle 35, pulse 30→25, data setup 12, address/CE to end 25.
- Slow grade (45): cycle 45, pulse 30, data setup 15, address/CE to end 30.

## Requirements
- R1: While reset is asserted and right after it, the outputs are in their idle levels: `sram_ce_no` and `sram_we_no` are high, `sram_dq_oe_o` is low, `busy_o` and `done_o` are low, and `req_ready_o` is high.
- R2: A request sampled with `req_ready_o` high starts a write on the next cycle. From then on, `sram_ce_no` is low, `busy_o` is high and `sram_addr_o` equals the request address, all constant for TOTAL cycles.
- R3: The first SETUP cycles of a write keep `sram_we_no` high with `sram_ce_no` low. `sram_we_no` is never low while `sram_ce_no` is high. `sram_dq_oe_o` is already high in the cycle before `sram_we_no` falls.
- R4: `sram_we_no` is low for exactly PULSE consecutive cycles. During those cycles `sram_dq_o` holds the request data and does not change.
- R5: Chip enable is low and the address is valid for at least the address/CE-to-end-of-write time before `sram_we_no` rises.
- R6: `sram_dq_oe_o` stays high in the first cycle after `sram_we_no` rises and is low from the cycle after that.
- R7: A write keeps `sram_ce_no` low for exactly TOTAL cycles, which is at least the write cycle time. `sram_addr_o` only changes while both strobes are high.
- R8: In the cycle after the last RECOVER cycle, `done_o` is high for exactly one cycle, `busy_o` is low and `req_ready_o` is high.
- R9: A request presented while `busy_o` is high is dropped. It does not change the address, length or data of the current write, and no write to its address follows.
- R10: `sram_store_no` is high at all times.
- R11: A request presented in the `done_o` cycle is accepted, and a second full write follows immediately with correct timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request strobe |
| req_addr_i | input | ADDR_W | Write address |
| req_data_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | High when a request will be accepted |
| busy_o | output | 1 | Write cycle in progress |
| done_o | output | 1 | One-cycle pulse at write completion |
| sram_addr_o | output | ADDR_W | RAM address |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_o | output | DATA_W | RAM write data |
| sram_dq_oe_o | output | 1 | Tri-state enable for the data bus |
| sram_store_no | output | 1 | Store control, held inactive high |

## Verification
A wrong phase state or phase count shows at the ports within the cycle it occurs, as a write-enable low window of the wrong length or at the wrong offset from the fall of chip enable. It can also show as a data-bus enable that is early or late relative to write enable. A stuck or skipped state shows as a chip-enable window that differs from TOTAL cycles, or as a missing or doubled done pulse in the cycle after recover. A bad capture enable shows up within one cycle in two ways: the address moves under an active strobe, or a poked request reaches the RAM model.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_RECOVER} wr_state_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // ceil(t/p), at least 1 when t is nonzero
  function automatic int ns_to_cyc(int t, int p);
    if (t == 0) return 0;
    return max2(1, (t + p - 1) / p);
  endfunction

  function automatic int t_cycle(int sg);
    return (sg == 45) ? 45 : 35;
  endfunction

  function automatic int t_pulse(int sg);
    return (sg == 45) ? 30 : 25;
  endfunction

  function automatic int t_dsetup(int sg);
    return (sg == 45) ? 15 : 12;
  endfunction

  function automatic int t_addr_end(int sg);
    return (sg == 45) ? 30 : 25;
  endfunction

  function automatic int t_ce_end(int sg);
    return (sg == 45) ? 30 : 25;
  endfunction

  function automatic int pulse_cyc(int sg, int p);
    return max2(ns_to_cyc(t_pulse(sg), p), ns_to_cyc(t_dsetup(sg), p));
  endfunction

  function automatic int setup_cyc(int sg, int p);
    return max2(1, max2(ns_to_cyc(t_addr_end(sg), p), ns_to_cyc(t_ce_end(sg), p))
                   - pulse_cyc(sg, p));
  endfunction

  function automatic int recover_cyc(int sg, int p);
    return max2(1, ns_to_cyc(t_cycle(sg), p) - setup_cyc(sg, p) - pulse_cyc(sg, p));
  endfunction

endpackage

// File: rtl/sram_wr_phase_cnt.sv
module sram_wr_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_hold.sv
module sram_wr_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (en_i)  q_o <= d_i;
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int SPEED_GRADE   = 35,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic              sram_store_no
);

  localparam int PULSE_CYC = pulse_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int SETUP_CYC = setup_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int REC_CYC   = recover_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int MAX_CYC   = max2(PULSE_CYC, max2(SETUP_CYC, REC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  wr_state_e        state_q, state_d;
  logic             ph_load, ph_zero;
  logic [CNT_W-1:0] ph_val;
  logic             accept;
  logic             oe_q, done_q;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  sram_wr_phase_cnt #(.CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ph_load),
    .load_val_i (ph_val),
    .zero_o     (ph_zero)
  );

  sram_wr_hold #(.W(ADDR_W + DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (accept),
    .d_i    ({req_addr_i, req_data_i}),
    .q_o    ({sram_addr_o, sram_dq_o})
  );

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP;
        ph_load = 1'b1;
        ph_val  = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (ph_zero) begin
        state_d = ST_PULSE;
        ph_load = 1'b1;
        ph_val  = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (ph_zero) begin
        state_d = ST_RECOVER;
        ph_load = 1'b1;
        ph_val  = CNT_W'(REC_CYC - 1);
      end
      ST_RECOVER: if (ph_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // bus driven through setup and pulse, plus one cycle after WE rises
      oe_q    <= (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_q == ST_PULSE);
      done_q  <= (state_q == ST_RECOVER) && (state_d == ST_IDLE);
    end
  end

  assign sram_ce_no    = (state_q == ST_IDLE);
  assign sram_we_no    = (state_q != ST_PULSE);
  assign sram_dq_oe_o  = oe_q;
  assign sram_store_no = 1'b1;
  assign busy_o        = (state_q != ST_IDLE);
  assign req_ready_o   = (state_q == ST_IDLE);
  assign done_o        = done_q;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk
  import sram_wr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int SPEED_GRADE   = 35,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);

  localparam int PULSE_CYC = pulse_cyc(SPEED_GRADE, CLK_PERIOD_NS);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_cnt <= '0;
    else if (!sram_we_no) we_low_cnt <= we_low_cnt + 1'b1;
    else                  we_low_cnt <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_ready_o));

  assert_we_needs_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);

  assert_oe_before_we_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(sram_dq_oe_o));

  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt == 16'(PULSE_CYC)));

  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> $stable(sram_dq_o));

  assert_oe_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);

  assert_oe_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |=> !sram_dq_oe_o);

  assert_addr_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sram_addr_o) |-> ($past(sram_ce_no) && $past(sram_we_no)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sram_addr_o));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SPEED_GRADE   (SPEED_GRADE),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/tb_sram_wr_seq.sv
`timescale 1ns/1ps
module tb_sram_wr_seq;

  localparam int CLK = 4;
  localparam int SG  = 35;
  localparam int AW  = 6;
  localparam int DW  = 8;

  function automatic int cdiv(int t);
    return (t + CLK - 1) / CLK;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_WC  = (SG == 45) ? 45 : 35;
  localparam int T_PW  = (SG == 45) ? 30 : 25;
  localparam int T_SD  = (SG == 45) ? 15 : 12;
  localparam int T_AW  = (SG == 45) ? 30 : 25;
  localparam int E_PUL = mx(cdiv(T_PW), cdiv(T_SD));
  localparam int E_SET = mx(1, cdiv(T_AW) - E_PUL);
  localparam int E_REC = mx(1, cdiv(T_WC) - E_SET - E_PUL);
  localparam int E_TOT = E_SET + E_PUL + E_REC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, busy, done;
  logic [AW-1:0] s_addr;
  logic          s_ce_n, s_we_n, s_oe, s_store_n;
  logic [DW-1:0] s_dq;

  int checks = 0;
  int errors = 0;
  int model_viol = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always #(CLK/2) clk = ~clk;

  sram_wr_seq #(.CLK_PERIOD_NS(CLK), .SPEED_GRADE(SG), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_data_i(req_data), .req_ready_o(req_ready), .busy_o(busy), .done_o(done),
    .sram_addr_o(s_addr), .sram_ce_no(s_ce_n), .sram_we_no(s_we_n), .sram_dq_o(s_dq),
    .sram_dq_oe_o(s_oe), .sram_store_no(s_store_n)
  );

  // behavioural RAM: latch on the rising edge of WE while selected
  always @(posedge s_we_n) if (rst_n && !s_ce_n && s_oe) mem[s_addr] <= s_dq;
  always @(s_addr) if (rst_n && !s_ce_n && !s_we_n) model_viol++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Sample index 0 = first cycle after the accepting edge
  task automatic capture(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit poke, input logic [AW-1:0] pa, input bit stop_at_done);
    int n_ce = 0, n_we = 0, first_lo = -1, rise = -1;
    int bad_r2 = 0, bad_r4 = 0, bad_r10 = 0, bad_r9 = 0;
    int oe_pre = 0, oe_at_rise = 0, oe_after = 1, set_hi = 1;
    int done_at = 0, done_after = 0, ready_at = 0;
    logic [DW-1:0] pa_old = mem[pa];
    int last = stop_at_done ? E_TOT : E_TOT + 3;
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      if (!s_store_n) bad_r10++;
      if (i < E_TOT) begin
        if (s_ce_n || !busy || req_ready || s_addr != a) bad_r2++;
        if (!s_ce_n) n_ce++;
        if (!s_we_n) begin
          n_we++;
          if (first_lo < 0) first_lo = i;
          if (s_dq != d) bad_r4++;
        end else if (first_lo >= 0 && rise < 0) begin
          rise = i;
          oe_at_rise = s_oe;
        end
        if (i < E_SET && !s_we_n) set_hi = 0;
        if (i == E_SET - 1) oe_pre = s_oe;
        if (rise >= 0 && i == rise + 1 && s_oe) oe_after = 0;
      end else if (i == E_TOT) begin
        done_at = done; ready_at = req_ready && !busy && s_ce_n;
        if (rise == E_TOT - 1 && s_oe) oe_after = 0;
        if (s_oe) oe_after = 0;
      end else begin
        if (done) done_after++;
        if (!s_ce_n) bad_r9++;
      end
      if (poke && i == 2) begin req_valid = 1'b1; req_addr = pa; req_data = ~d; end
      if (poke && i == 4) req_valid = 1'b0;
    end
    chk(bad_r2 == 0, "R2 CE/busy/addr held", bad_r2, 0);
    chk(set_hi == 1 && first_lo == E_SET && oe_pre == 1, "R3 setup phase", first_lo, E_SET);
    chk(n_we == E_PUL && bad_r4 == 0, "R4 WE low width/data", n_we, E_PUL);
    chk(rise * CLK >= T_AW, "R5 addr/CE to end of write ns", rise * CLK, T_AW);
    chk(oe_at_rise == 1 && oe_after == 1, "R6 OE release", oe_at_rise, 1);
    chk(n_ce == E_TOT && E_TOT * CLK >= T_WC, "R7 CE low cycles", n_ce, E_TOT);
    chk(done_at == 1 && ready_at == 1, "R8 done/ready", done_at, 1);
    chk(bad_r10 == 0, "R10 store line high", bad_r10, 0);
    if (!stop_at_done) chk(done_after == 0, "R8 done single cycle", done_after, 0);
    chk(mem[a] == d, "R2 RAM model content", int'(mem[a]), int'(d));
    if (poke) chk(bad_r9 == 0 && mem[pa] == pa_old, "R9 busy request ignored",
                  int'(mem[pa]), int'(pa_old));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(s_ce_n && s_we_n && !s_oe && !busy && !done && req_ready, "R1 in reset",
        {s_ce_n, s_we_n, s_oe, busy, done, req_ready}, 6'b110001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ce_n && s_we_n && !s_oe && !busy && !done && req_ready && s_store_n,
        "R1 after reset", {s_ce_n, s_we_n, s_oe, busy, done, req_ready}, 6'b110001);
  endtask

  task automatic t_single(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    issue(a, d);
    capture(a, d, 1'b0, '0, 1'b0);
  endtask

  task automatic t_poke;
    @(negedge clk);
    issue(6'h15, 8'h3C);
    capture(6'h15, 8'h3C, 1'b1, 6'h2A, 1'b0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    issue(6'h07, 8'h11);
    capture(6'h07, 8'h11, 1'b0, '0, 1'b1);
    issue(6'h08, 8'hEE);  // presented in the done cycle
    capture(6'h08, 8'hEE, 1'b0, '0, 1'b0);
    chk(model_viol == 0, "R11 address stable under strobes", model_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    t_reset();
    t_single(6'h00, 8'hA5);
    t_single(6'h3F, 8'hFF);
    t_single(6'h21, 8'h00);
    t_poke();
    t_back_to_back();
    chk(model_viol == 0, "R7 no address change under active strobes", model_viol, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule